// File: doc/BRIEF.md
# Segmented TLP receive packet tracker

The tracker sits behind a wide receive stream that presents four parallel 256-bit segments on every clock. Each segment has its own start, end and qualifier flags, and it carries a header, a prefix dword, an empty-dword count and routing metadata. The block follows packet boundaries across segments and across cycles. It captures the header, prefix and routing fields of each packet at its start. When a packet's end is seen, the block produces one record for it. The record holds the captured header and prefix, the decoded prefix Fmt/Type, the BAR, the target function, the packet length in dwords and a flag that marks a parity error found anywhere in the packet.

The stream has no backpressure. The block's ready output is tied high, and every qualified segment is taken on the cycle it appears. Within a cycle the segments are handled in ascending index order. A packet can therefore close in one segment while the next packet opens in a higher segment of the same cycle, and the block can deliver up to four records per clock. Each record is placed on the output lane whose index equals the segment that held the packet's end. A start seen while a packet is open, or an end seen while none is open, sets a sticky protocol-error output. The tracker picks up again at the next start.

Top module: `seg_rx_pkt_tracker`

## Requirements
- R1: `out_ready` is 1 in every cycle, including during reset.
- R2: A segment whose `in_dvalid` bit is 0 has no effect. Its start, end, empty, header and parity inputs change no record and no error output.
- R3: A record for a packet appears on lane k of the `rec_*` outputs (`rec_valid[k]`=1) in the clock cycle after the input cycle in which segment k carried the packet's qualified end. Segments are handled in order 0 to 3, so several records may appear together.
- R4: `rec_len` = 8 × (number of qualified segments of the packet) − `in_empty` of the end segment. The empty field is ignored on segments that do not carry an end.
- R5: `rec_hdr` holds the header of the start segment if its `in_hvalid` was 1, and zero otherwise. `rec_pfx` works the same way using `in_pvalid`. `rec_pfx_present` = (`rec_pfx` ≠ 0), `rec_pfx_fmt` = `rec_pfx[31:29]` and `rec_pfx_type` = `rec_pfx[28:24]`.
- R6: `rec_bar` and `rec_vf_act` are the values sampled at the start segment. `rec_fn_num` is the 11-bit VF number when `rec_vf_act` is 1, and otherwise the 3-bit PF number zero-extended.
- R7: Parity is even. Parity bit i of a field equals the XOR of bits 32i+31..32i of that field. Data parity (8 bits per segment) is checked on every qualified segment of a packet. Header parity (4 bits) is checked at the start when `in_hvalid` is 1. Prefix parity (1 bit) is checked at the start when `in_pvalid` is 1. Any mismatch sets `rec_perr` of that packet's record, and unchecked parity has no effect.
- R8: A qualified start while a packet is open, or a qualified end while no packet is open, sets `proto_err`. The flag stays 1 until reset. A start while a packet is open drops the old packet with no record and opens the new one.
- R9: After reset, `rec_valid` is 0, `proto_err` is 0 and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 1024 | Segment data, segment k in bits [256k+255:256k] |
| in_data_par | input | 32 | Data parity, 8 bits per segment |
| in_hdr | input | 512 | Header, 128 bits per segment |
| in_hdr_par | input | 16 | Header parity, 4 bits per segment |
| in_pfx | input | 128 | Prefix dword, 32 bits per segment |
| in_pfx_par | input | 4 | Prefix parity, one bit per segment |
| in_sop | input | 4 | Start flag per segment |
| in_eop | input | 4 | End flag per segment |
| in_dvalid | input | 4 | Segment qualifier |
| in_hvalid | input | 4 | Header qualifier |
| in_pvalid | input | 4 | Prefix qualifier |
| in_empty | input | 12 | Unused dwords at end, 3 bits per segment |
| in_bar | input | 12 | BAR, 3 bits per segment |
| in_vf_act | input | 4 | Virtual-function target flag per segment |
| in_vf_num | input | 44 | VF number, 11 bits per segment |
| in_pf_num | input | 12 | PF number, 3 bits per segment |
| out_ready | output | 1 | Always-high ready |
| rec_valid | output | 4 | Record present on lane k |
| rec_hdr | output | 512 | Record header, 128 bits per lane |
| rec_pfx | output | 128 | Record prefix, 32 bits per lane |
| rec_pfx_present | output | 4 | Prefix non-zero per lane |
| rec_pfx_fmt | output | 12 | Prefix Fmt, 3 bits per lane |
| rec_pfx_type | output | 20 | Prefix Type, 5 bits per lane |
| rec_bar | output | 12 | Record BAR, 3 bits per lane |
| rec_vf_act | output | 4 | Record VF flag per lane |
| rec_fn_num | output | 44 | Target function number, 11 bits per lane |
| rec_len | output | 48 | Length in dwords, 12 bits per lane |
| rec_perr | output | 4 | Parity error flag per lane |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The hardest cases are the ones where one cycle closes a packet and opens another, or holds several complete packets, while an unqualified segment sits inside a packet with stray start, end and empty values. A bad parity bit must also be traced to the right record. The stimulus is a packing pointer that lays packets of one to six segments into consecutive segment slots and wraps across cycles. The sweep varies the start offset, the span, the empty count, unqualified holes, the qualifiers and which parity group is corrupted. Because of this, packets begin and end at every segment position and often share cycles with their neighbours. Short directed sequences then force a start inside an open packet and an end with nothing open, and check recovery afterwards.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;
   localparam int GRP_W   = 32;
   localparam int HDR_W   = 128;
   localparam int PFX_W   = 32;
   localparam int BAR_W   = 3;
   localparam int VFN_W   = 11;
   localparam int PFN_W   = 3;
   localparam int EMPTY_W = 3;
   localparam int LEN_W   = 12;
   localparam int HPAR_W  = HDR_W / GRP_W;
   localparam int PPAR_W  = PFX_W / GRP_W;

   typedef struct packed {
      logic [BAR_W-1:0] bar;
      logic             vf_act;
      logic [VFN_W-1:0] vf_num;
      logic [PFN_W-1:0] pf_num;
   } route_t;

   typedef struct packed {
      logic             open;
      logic [HDR_W-1:0] hdr;
      logic [PFX_W-1:0] pfx;
      route_t           route;
      logic             perr;
      logic [LEN_W-1:0] cnt;
   } pkt_ctx_t;
endpackage

// File: rtl/seg_rx_parity.sv
module seg_rx_parity #(
   parameter int W     = 256,
   parameter int GRP_W = 32
) (
   input  logic [W-1:0]       bits_i,
   input  logic [W/GRP_W-1:0] par_i,
   input  logic               en_i,
   output logic               err_o
);
   localparam int NGRP = W / GRP_W;

   logic [NGRP-1:0] miss;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign miss[g] = (^bits_i[g*GRP_W +: GRP_W]) ^ par_i[g];
   end

   assign err_o = en_i & (|miss);
endmodule

// File: rtl/seg_rx_stage.sv
module seg_rx_stage
   import seg_rx_pkg::*;
#(
   parameter int SEG_DW = 256
) (
   input  pkt_ctx_t                   ctx_i,
   input  logic [SEG_DW-1:0]          data_i,
   input  logic [SEG_DW/GRP_W-1:0]    data_par_i,
   input  logic [HDR_W-1:0]           hdr_i,
   input  logic [HPAR_W-1:0]          hdr_par_i,
   input  logic [PFX_W-1:0]           pfx_i,
   input  logic [PPAR_W-1:0]          pfx_par_i,
   input  logic                       sop_i,
   input  logic                       eop_i,
   input  logic                       dvalid_i,
   input  logic                       hvalid_i,
   input  logic                       pvalid_i,
   input  logic [EMPTY_W-1:0]         empty_i,
   input  route_t                     route_i,
   output pkt_ctx_t                   ctx_o,
   output logic                       rec_valid_o,
   output pkt_ctx_t                   rec_ctx_o,
   output logic [LEN_W-1:0]           rec_len_o,
   output logic                       proto_o
);
   localparam int DW_PER_SEG = SEG_DW / GRP_W;

   logic d_err, h_err, p_err;

   seg_rx_parity #(.W(SEG_DW), .GRP_W(GRP_W)) u_dpar (
      .bits_i(data_i), .par_i(data_par_i), .en_i(dvalid_i), .err_o(d_err));
   seg_rx_parity #(.W(HDR_W), .GRP_W(GRP_W)) u_hpar (
      .bits_i(hdr_i), .par_i(hdr_par_i), .en_i(dvalid_i & sop_i & hvalid_i), .err_o(h_err));
   seg_rx_parity #(.W(PFX_W), .GRP_W(GRP_W)) u_ppar (
      .bits_i(pfx_i), .par_i(pfx_par_i), .en_i(dvalid_i & sop_i & pvalid_i), .err_o(p_err));

   always_comb begin
      ctx_o       = ctx_i;
      rec_valid_o = 1'b0;
      rec_ctx_o   = ctx_i;
      rec_len_o   = '0;
      proto_o     = 1'b0;
      if (dvalid_i) begin
         if (sop_i) begin
            proto_o      = ctx_i.open;
            ctx_o.open   = 1'b1;
            ctx_o.hdr    = hvalid_i ? hdr_i : '0;
            ctx_o.pfx    = pvalid_i ? pfx_i : '0;
            ctx_o.route  = route_i;
            ctx_o.cnt    = LEN_W'(1);
            ctx_o.perr   = d_err | h_err | p_err;
         end else if (ctx_i.open) begin
            ctx_o.cnt    = ctx_i.cnt + LEN_W'(1);
            ctx_o.perr   = ctx_i.perr | d_err;
         end
         if (eop_i) begin
            if (ctx_o.open) begin
               rec_valid_o = 1'b1;
               rec_ctx_o   = ctx_o;
               rec_len_o   = ctx_o.cnt * LEN_W'(DW_PER_SEG) - LEN_W'(empty_i);
               ctx_o.open  = 1'b0;
            end else begin
               proto_o     = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/seg_rx_pkt_tracker.sv
module seg_rx_pkt_tracker
   import seg_rx_pkg::*;
#(
   parameter int NSEG   = 4,
   parameter int SEG_DW = 256
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [NSEG*SEG_DW-1:0]          in_data,
   input  logic [NSEG*(SEG_DW/32)-1:0]     in_data_par,
   input  logic [NSEG*128-1:0]             in_hdr,
   input  logic [NSEG*4-1:0]               in_hdr_par,
   input  logic [NSEG*32-1:0]              in_pfx,
   input  logic [NSEG-1:0]                 in_pfx_par,
   input  logic [NSEG-1:0]                 in_sop,
   input  logic [NSEG-1:0]                 in_eop,
   input  logic [NSEG-1:0]                 in_dvalid,
   input  logic [NSEG-1:0]                 in_hvalid,
   input  logic [NSEG-1:0]                 in_pvalid,
   input  logic [NSEG*3-1:0]               in_empty,
   input  logic [NSEG*3-1:0]               in_bar,
   input  logic [NSEG-1:0]                 in_vf_act,
   input  logic [NSEG*11-1:0]              in_vf_num,
   input  logic [NSEG*3-1:0]               in_pf_num,
   output logic                            out_ready,
   output logic [NSEG-1:0]                 rec_valid,
   output logic [NSEG*128-1:0]             rec_hdr,
   output logic [NSEG*32-1:0]              rec_pfx,
   output logic [NSEG-1:0]                 rec_pfx_present,
   output logic [NSEG*3-1:0]               rec_pfx_fmt,
   output logic [NSEG*5-1:0]               rec_pfx_type,
   output logic [NSEG*3-1:0]               rec_bar,
   output logic [NSEG-1:0]                 rec_vf_act,
   output logic [NSEG*11-1:0]              rec_fn_num,
   output logic [NSEG*12-1:0]              rec_len,
   output logic [NSEG-1:0]                 rec_perr,
   output logic                            proto_err
);
   localparam int DPAR_W = SEG_DW / GRP_W;

   // elaboration-time parameter checks
   if (NSEG < 1) begin : g_bad_nseg
      $error("NSEG must be at least 1");
   end
   if (SEG_DW % GRP_W != 0) begin : g_bad_segw
      $error("SEG_DW must be a multiple of the parity group width");
   end
   if (DPAR_W > (1 << EMPTY_W)) begin : g_bad_empty
      $error("empty field too narrow for segment dword count");
   end

   assign out_ready = 1'b1;

   pkt_ctx_t         chain   [NSEG+1];
   pkt_ctx_t         ctx_q;
   logic [NSEG-1:0]  rv_d;
   logic [NSEG-1:0]  pv_d;
   pkt_ctx_t         rc_d    [NSEG];
   logic [LEN_W-1:0] rl_d    [NSEG];
   pkt_ctx_t         rc_q    [NSEG];
   logic [LEN_W-1:0] rl_q    [NSEG];
   logic [NSEG-1:0]  rv_q;
   logic             perr_sticky_q;

   assign chain[0] = ctx_q;

   for (genvar k = 0; k < NSEG; k++) begin : g_seg
      route_t rt;
      assign rt.bar    = in_bar[k*BAR_W +: BAR_W];
      assign rt.vf_act = in_vf_act[k];
      assign rt.vf_num = in_vf_num[k*VFN_W +: VFN_W];
      assign rt.pf_num = in_pf_num[k*PFN_W +: PFN_W];

      seg_rx_stage #(.SEG_DW(SEG_DW)) u_stage (
         .ctx_i      (chain[k]),
         .data_i     (in_data[k*SEG_DW +: SEG_DW]),
         .data_par_i (in_data_par[k*DPAR_W +: DPAR_W]),
         .hdr_i      (in_hdr[k*HDR_W +: HDR_W]),
         .hdr_par_i  (in_hdr_par[k*HPAR_W +: HPAR_W]),
         .pfx_i      (in_pfx[k*PFX_W +: PFX_W]),
         .pfx_par_i  (in_pfx_par[k*PPAR_W +: PPAR_W]),
         .sop_i      (in_sop[k]),
         .eop_i      (in_eop[k]),
         .dvalid_i   (in_dvalid[k]),
         .hvalid_i   (in_hvalid[k]),
         .pvalid_i   (in_pvalid[k]),
         .empty_i    (in_empty[k*EMPTY_W +: EMPTY_W]),
         .route_i    (rt),
         .ctx_o      (chain[k+1]),
         .rec_valid_o(rv_d[k]),
         .rec_ctx_o  (rc_d[k]),
         .rec_len_o  (rl_d[k]),
         .proto_o    (pv_d[k])
      );

      assign rec_valid[k]                    = rv_q[k];
      assign rec_hdr[k*HDR_W +: HDR_W]       = rc_q[k].hdr;
      assign rec_pfx[k*PFX_W +: PFX_W]       = rc_q[k].pfx;
      assign rec_pfx_present[k]              = |rc_q[k].pfx;
      assign rec_pfx_fmt[k*3 +: 3]           = rc_q[k].pfx[PFX_W-1 -: 3];
      assign rec_pfx_type[k*5 +: 5]          = rc_q[k].pfx[PFX_W-4 -: 5];
      assign rec_bar[k*BAR_W +: BAR_W]       = rc_q[k].route.bar;
      assign rec_vf_act[k]                   = rc_q[k].route.vf_act;
      assign rec_fn_num[k*VFN_W +: VFN_W]    = rc_q[k].route.vf_act ? rc_q[k].route.vf_num
                                               : VFN_W'(rc_q[k].route.pf_num);
      assign rec_len[k*LEN_W +: LEN_W]       = rl_q[k];
      assign rec_perr[k]                     = rc_q[k].perr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctx_q         <= '0;
         rv_q          <= '0;
         perr_sticky_q <= 1'b0;
         for (int k = 0; k < NSEG; k++) begin
            rc_q[k] <= '0;
            rl_q[k] <= '0;
         end
      end else begin
         ctx_q         <= chain[NSEG];
         rv_q          <= rv_d;
         perr_sticky_q <= perr_sticky_q | (|pv_d);
         for (int k = 0; k < NSEG; k++) begin
            if (rv_d[k]) begin
               rc_q[k] <= rc_d[k];
               rl_q[k] <= rl_d[k];
            end
         end
      end
   end

   assign proto_err = perr_sticky_q;
endmodule

// File: rtl/seg_rx_pkt_tracker_chk.sv
module seg_rx_pkt_tracker_chk #(
   parameter int NSEG = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NSEG-1:0]      in_eop,
   input logic [NSEG-1:0]      in_dvalid,
   input logic [NSEG-1:0]      rec_valid,
   input logic [NSEG-1:0]      rec_vf_act,
   input logic [NSEG*11-1:0]   rec_fn_num,
   input logic [NSEG-1:0]      rec_pfx_present,
   input logic [NSEG*3-1:0]    rec_pfx_fmt,
   input logic [NSEG*5-1:0]    rec_pfx_type,
   input logic [NSEG*12-1:0]   rec_len,
   input logic                 proto_err
);
   // R3: a record lane fires only after a qualified end on that segment
   a_r3_lane_from_end: assert property (@(posedge clk) disable iff (rst)
      ((rec_valid & ~$past(in_eop & in_dvalid)) == '0));

   // R2: a cycle with no qualified segment produces no record
   a_r2_idle_no_record: assert property (@(posedge clk) disable iff (rst)
      ($past(in_dvalid) == '0) |-> (rec_valid == '0));

   // R8: protocol error is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err);

   for (genvar k = 0; k < NSEG; k++) begin : g_lane
      // R6: PF target numbers never use the upper bits
      a_r6_pf_narrow: assert property (@(posedge clk) disable iff (rst)
         (rec_valid[k] && !rec_vf_act[k]) |-> (rec_fn_num[k*11+3 +: 8] == '0));
      // R5: an absent prefix decodes to zero fields
      a_r5_no_pfx_fields: assert property (@(posedge clk) disable iff (rst)
         (rec_valid[k] && !rec_pfx_present[k]) |->
         (rec_pfx_fmt[k*3 +: 3] == '0 && rec_pfx_type[k*5 +: 5] == '0));
      // R4: a packet is never shorter than one dword
      a_r4_len_nonzero: assert property (@(posedge clk) disable iff (rst)
         rec_valid[k] |-> (rec_len[k*12 +: 12] != '0));
   end
endmodule

bind seg_rx_pkt_tracker seg_rx_pkt_tracker_chk #(.NSEG(NSEG)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .in_eop         (in_eop),
   .in_dvalid      (in_dvalid),
   .rec_valid      (rec_valid),
   .rec_vf_act     (rec_vf_act),
   .rec_fn_num     (rec_fn_num),
   .rec_pfx_present(rec_pfx_present),
   .rec_pfx_fmt    (rec_pfx_fmt),
   .rec_pfx_type   (rec_pfx_type),
   .rec_len        (rec_len),
   .proto_err      (proto_err)
);

// File: tb/seg_rx_pkt_tracker_bench.sv
`timescale 1ns/1ps
module seg_rx_pkt_tracker_bench;
   localparam int NS = 4;
   localparam int SW = 256;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [NS*SW-1:0] in_data;
   logic [NS*8-1:0]  in_data_par;
   logic [NS*128-1:0] in_hdr;
   logic [NS*4-1:0]  in_hdr_par;
   logic [NS*32-1:0] in_pfx;
   logic [NS-1:0]    in_pfx_par, in_sop, in_eop, in_dvalid, in_hvalid, in_pvalid, in_vf_act;
   logic [NS*3-1:0]  in_empty, in_bar, in_pf_num;
   logic [NS*11-1:0] in_vf_num;
   logic             out_ready, proto_err;
   logic [NS-1:0]    rec_valid, rec_pfx_present, rec_vf_act, rec_perr;
   logic [NS*128-1:0] rec_hdr;
   logic [NS*32-1:0] rec_pfx;
   logic [NS*3-1:0]  rec_pfx_fmt, rec_bar;
   logic [NS*5-1:0]  rec_pfx_type;
   logic [NS*11-1:0] rec_fn_num;
   logic [NS*12-1:0] rec_len;

   seg_rx_pkt_tracker u_seg_rx_pkt_tracker (.*);

   int checks = 0, errors = 0, cycles = 0, gseg = 0, seed = 1;
   logic [NS-1:0] exp_v, exp_perr, exp_vfa;
   logic [127:0]  exp_hdr [NS];
   logic [31:0]   exp_pfx [NS];
   logic [11:0]   exp_len [NS];
   logic [2:0]    exp_bar [NS];
   logic [10:0]   exp_fn  [NS];

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      in_data = '0; in_data_par = '0; in_hdr = '0; in_hdr_par = '0; in_pfx = '0;
      in_pfx_par = '0; in_sop = '0; in_eop = '0; in_dvalid = '0; in_hvalid = '0;
      in_pvalid = '0; in_empty = '0; in_bar = '0; in_pf_num = '0; in_vf_num = '0;
      in_vf_act = '0; exp_v = '0; gseg = 0;
   endtask

   // clock one input cycle and compare the records that follow it
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < NS; k++) begin
         chk(rec_valid[k] == exp_v[k], $sformatf("R3 lane %0d valid", k), 128'(rec_valid[k]), 128'(exp_v[k]));
         if (exp_v[k] && rec_valid[k]) begin
            chk(rec_len[k*12 +: 12] == exp_len[k], "R4 length", 128'(rec_len[k*12 +: 12]), 128'(exp_len[k]));
            chk(rec_hdr[k*128 +: 128] == exp_hdr[k], "R5 header", rec_hdr[k*128 +: 128], exp_hdr[k]);
            chk(rec_pfx[k*32 +: 32] == exp_pfx[k], "R5 prefix", 128'(rec_pfx[k*32 +: 32]), 128'(exp_pfx[k]));
            chk(rec_pfx_present[k] == (exp_pfx[k] != 0), "R5 present", 128'(rec_pfx_present[k]), 128'(exp_pfx[k] != 0));
            chk(rec_pfx_fmt[k*3 +: 3] == exp_pfx[k][31:29], "R5 fmt", 128'(rec_pfx_fmt[k*3 +: 3]), 128'(exp_pfx[k][31:29]));
            chk(rec_pfx_type[k*5 +: 5] == exp_pfx[k][28:24], "R5 type", 128'(rec_pfx_type[k*5 +: 5]), 128'(exp_pfx[k][28:24]));
            chk(rec_bar[k*3 +: 3] == exp_bar[k], "R6 bar", 128'(rec_bar[k*3 +: 3]), 128'(exp_bar[k]));
            chk(rec_vf_act[k] == exp_vfa[k], "R6 vf flag", 128'(rec_vf_act[k]), 128'(exp_vfa[k]));
            chk(rec_fn_num[k*11 +: 11] == exp_fn[k], "R6 function", 128'(rec_fn_num[k*11 +: 11]), 128'(exp_fn[k]));
            chk(rec_perr[k] == exp_perr[k], "R7 parity flag", 128'(rec_perr[k]), 128'(exp_perr[k]));
         end
      end
      clear_in();
   endtask

   // place one segment; kind 1/2/3 corrupts data/header/prefix parity
   task automatic put_raw(input int k, input bit sop, input bit eop, input bit dv, input bit hv,
                          input bit pv, input int empty, input logic [127:0] hdr, input logic [31:0] pfx,
                          input int bar, input bit vfa, input int vfn, input int pfn, input int kind);
      logic [255:0] d;
      logic [7:0] dp;
      logic [3:0] hp;
      for (int g = 0; g < 8; g++) begin
         d[g*32 +: 32] = 32'(seed * 131 + g * 17 + k * 977);
         dp[g] = ^d[g*32 +: 32];
      end
      for (int g = 0; g < 4; g++) hp[g] = ^hdr[g*32 +: 32];
      if (kind == 1) dp[seed % 8] = ~dp[seed % 8];
      if (kind == 2) hp[seed % 4] = ~hp[seed % 4];
      seed++;
      in_data[k*SW +: SW] = d;         in_data_par[k*8 +: 8] = dp;
      in_hdr[k*128 +: 128] = hdr;      in_hdr_par[k*4 +: 4] = hp;
      in_pfx[k*32 +: 32] = pfx;        in_pfx_par[k] = (^pfx) ^ (kind == 3);
      in_sop[k] = sop; in_eop[k] = eop; in_dvalid[k] = dv; in_hvalid[k] = hv; in_pvalid[k] = pv;
      in_empty[k*3 +: 3] = 3'(empty);  in_bar[k*3 +: 3] = 3'(bar);
      in_vf_act[k] = vfa; in_vf_num[k*11 +: 11] = 11'(vfn); in_pf_num[k*3 +: 3] = 3'(pfn);
   endtask

   task automatic adv();
      gseg++;
      if (gseg == NS) step();
   endtask

   task automatic send_pkt(input int n, input int empty, input bit hv, input bit pv,
                           input logic [31:0] pfx, input int bar, input bit vfa, input int vfn,
                           input int pfn, input int kind, input int bad_seg, input bit hole);
      logic [127:0] hdr;
      bit perr;
      hdr = {32'(seed * 7), 32'(seed + 3), 32'(~seed), 32'(seed * 31 + 5)};
      perr = (kind == 1) || (kind == 2 && hv) || (kind == 3 && pv);
      for (int i = 0; i < n; i++) begin
         if (hole && i == 1) begin
            put_raw(gseg, 1, 1, 0, 1, 1, 6, ~hdr, 32'hFFFF_FFFF, 7, 1, 2047, 7, 1);
            adv();
         end
         put_raw(gseg, i == 0, i == n - 1, 1, hv && i == 0, pv && i == 0,
                 (i == n - 1) ? empty : (empty + 5) % 8, (i == 0) ? hdr : ~hdr,
                 (i == 0) ? pfx : 32'hDEAD_BEEF, (i == 0) ? bar : 5, (i == 0) ? vfa : !vfa,
                 (i == 0) ? vfn : 99, (i == 0) ? pfn : 6,
                 (kind == 1 && i == bad_seg) ? 1 : ((kind > 1 && i == 0) ? kind : 0));
         if (i == n - 1) begin
            exp_v[gseg]    = 1'b1;
            exp_len[gseg]  = 12'(n * 8 - empty);
            exp_hdr[gseg]  = hv ? hdr : '0;
            exp_pfx[gseg]  = pv ? pfx : '0;
            exp_bar[gseg]  = 3'(bar);
            exp_vfa[gseg]  = vfa;
            exp_fn[gseg]   = vfa ? 11'(vfn) : 11'(pfn);
            exp_perr[gseg] = perr;
         end
         adv();
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
         end
      end
   end

   task automatic do_reset();
      rst = 1'b1;
      clear_in();
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(out_ready == 1'b1, "R1 ready during reset", 128'(out_ready), 128'(1));
      rst = 1'b0;
   endtask

   initial begin
      clear_in();
      do_reset();
      @(negedge clk);
      chk(rec_valid == '0, "R9 no record after reset", 128'(rec_valid), 128'(0));
      chk(proto_err == 1'b0, "R9 error clear after reset", 128'(proto_err), 128'(0));
      chk(out_ready == 1'b1, "R1 ready after reset", 128'(out_ready), 128'(1));

      // sweep: start offset, span, empty count, qualifiers, parity faults, holes
      for (int s = 0; s < 4; s++)
         for (int n = 1; n <= 6; n++)
            for (int e = 0; e < 8; e++) begin
               int kind;
               logic [31:0] pfx;
               kind = (n * 8 + e + s) % 5;
               if (kind > 3) kind = 0;
               pfx = (e % 3 == 0) ? 32'h0 : {3'(e), 5'(n + s), 24'(seed * 13)};
               if ((e + s) % 2 == 1) adv();
               send_pkt(n, e, (e + n) % 3 != 0, e % 4 != 1, pfx, (s + e) % 8, (n + e) % 2 == 1,
                        n * 300 + e * 7 + s, (e + s) % 8, kind, e % n, e == 3 && n > 1);
            end
      if (gseg != 0) step();
      step();
      chk(proto_err == 1'b0, "R2 stray flags on unqualified segments raise no error", 128'(proto_err), 128'(0));
      chk(out_ready == 1'b1, "R1 ready during traffic", 128'(out_ready), 128'(1));

      // R8: start while open drops the old packet and keeps the new one
      put_raw(0, 1, 0, 1, 1, 1, 0, 128'h1111, 32'h0, 1, 0, 0, 1, 0);
      gseg = 1;
      send_pkt(1, 2, 1, 1, 32'h4A00_0001, 3, 0, 0, 5, 0, 0, 0);
      step();
      chk(proto_err == 1'b1, "R8 start while open", 128'(proto_err), 128'(1));
      send_pkt(2, 0, 1, 0, 32'h0, 2, 1, 1234, 0, 0, 0, 0);
      step();
      chk(proto_err == 1'b1, "R8 error stays set", 128'(proto_err), 128'(1));

      // R8: end with nothing open, then recovery at the next start
      do_reset();
      @(negedge clk);
      put_raw(0, 0, 1, 1, 0, 0, 1, 128'h0, 32'h0, 0, 0, 0, 0, 0);
      gseg = 1;
      send_pkt(3, 7, 1, 1, 32'h6C12_3456, 4, 0, 0, 3, 0, 0, 0);
      step();
      step();
      chk(proto_err == 1'b1, "R8 end with nothing open", 128'(proto_err), 128'(1));

      // R2: qualified-off start/end alone produce nothing
      do_reset();
      @(negedge clk);
      put_raw(2, 1, 1, 0, 1, 1, 0, 128'h55, 32'h1, 1, 0, 0, 1, 1);
      step();
      step();
      chk(proto_err == 1'b0, "R2 unqualified start and end ignored", 128'(proto_err), 128'(0));
      finish_run();
   end
endmodule